// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the 12-bit memory address used by the load and store operations of a small accumulator processor. A request carries an addressing mode, the page register (of which only the low four bits count), the low-byte register, the two index registers and up to two operand bytes. The block picks a base address and an 8-bit offset for the chosen mode. A single modular adder adds them, and the result is registered into an output slot.

Requests arrive on a valid/ready channel, and addresses leave on a second valid/ready channel. The output slot holds one address. While that address waits for the consumer, the request side reports not ready, so back-pressure reaches the producer with no extra buffering. When the consumer takes the held address in the same cycle that a new request is offered, the new request is accepted at once. Back-to-back requests therefore flow at one address per cycle.

Mode codes: 0 register-indirect, 1 indexed by B, 2 indexed by C, 3 page zero, 4 page-register page plus operand, 5 pointer plus operand, 6 absolute, 7 reserved.

Top module: `eagen_top`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Mode 0 (and only the low 4 bits of `in_h` count in every mode) gives `out_addr = {in_h[3:0], in_l}`.
- R3: Modes 1 and 2 give `{in_h[3:0], in_l}` plus `in_b` (mode 1) or `in_c` (mode 2), modulo 4096.
- R4: Mode 3 gives `out_addr = {4'h0, in_op0}`; `in_h` and `in_l` have no effect.
- R5: Mode 4 gives `out_addr = {in_h[3:0], in_op0}`; `in_l` has no effect.
- R6: Mode 5 gives `{in_h[3:0], in_l}` plus `in_op0`, modulo 4096, and drops any carry out of bit 11.
- R7: Mode 6 gives `out_addr = {in_op0[3:0], in_op1}`: the first operand byte is most significant, and its upper nibble has no effect.
- R8: A request accepted on a clock edge (`in_valid` and `in_ready` both high) sets `out_valid` from that edge, with its address on `out_addr`.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_addr` stay unchanged and no request is taken.
- R10: When the held address is consumed and no request is offered, `out_valid` drops on that edge.
- R11: Reserved mode 7 yields the same address as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 3 | Addressing mode code |
| in_h | input | 8 | Page register (low 4 bits used) |
| in_l | input | 8 | Low-byte register |
| in_b | input | 8 | First index register |
| in_c | input | 8 | Second index register |
| in_op0 | input | 8 | First operand byte |
| in_op1 | input | 8 | Second operand byte |
| out_valid | output | 1 | Address slot holds a result |
| out_ready | input | 1 | Consumer takes the address this cycle |
| out_addr | output | 12 | Effective address |

## Verification
Two events can land on the same edge: the consumer draining the held address and the producer handing over a new request. The bench provokes this overlap in two ways. It streams its vector table with `out_ready` held high, so every edge both drains and refills the slot. It also stalls the consumer with a request pending and then raises `out_ready` while that request is still offered. The bench judges the overlap by checking that the stalled address holds unchanged during the stall. It then checks that the pending request's address replaces the stalled one on the release edge, with no idle cycle between them.

// File: rtl/eagen_pkg.sv
package eagen_pkg;
  typedef enum logic [2:0] {
    EA_IND   = 3'd0,
    EA_IDXB  = 3'd1,
    EA_IDXC  = 3'd2,
    EA_ZPG   = 3'd3,
    EA_HPG   = 3'd4,
    EA_HLOFS = 3'd5,
    EA_ABS   = 3'd6,
    EA_RSV   = 3'd7
  } ea_mode_e;
endpackage

// File: rtl/eagen_operand_sel.sv
module eagen_operand_sel
  import eagen_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  ea_mode_e        mode,
  input  logic [DW-1:0]   h,
  input  logic [DW-1:0]   l,
  input  logic [DW-1:0]   b,
  input  logic [DW-1:0]   c,
  input  logic [DW-1:0]   op0,
  input  logic [DW-1:0]   op1,
  output logic [AW-1:0]   base,
  output logic [DW-1:0]   offs
);
  localparam int HW = AW - DW;

  logic [AW-1:0] ptr;
  assign ptr = {h[HW-1:0], l};

  always_comb begin
    base = ptr;
    offs = '0;
    unique case (mode)
      EA_IND:   begin base = ptr;                   offs = '0;  end
      EA_IDXB:  begin base = ptr;                   offs = b;   end
      EA_IDXC:  begin base = ptr;                   offs = c;   end
      EA_ZPG:   begin base = {{HW{1'b0}}, op0};     offs = '0;  end
      EA_HPG:   begin base = {h[HW-1:0], op0};      offs = '0;  end
      EA_HLOFS: begin base = ptr;                   offs = op0; end
      EA_ABS:   begin base = {op0[HW-1:0], op1};    offs = '0;  end
      EA_RSV:   begin base = ptr;                   offs = '0;  end
      default:  begin base = ptr;                   offs = '0;  end
    endcase
  end
endmodule

// File: rtl/eagen_adder.sv
module eagen_adder #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] offs,
  output logic [AW-1:0] sum
);
  localparam int HW = AW - DW;

  // Result width equals the address width: carry out of the top bit is lost.
  assign sum = base + {{HW{1'b0}}, offs};
endmodule

// File: rtl/eagen_out_stage.sv
module eagen_out_stage #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] next_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= next_addr;
    end
  end
endmodule

// File: rtl/eagen_top.sv
module eagen_top
  import eagen_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_mode,
  input  logic [DW-1:0] in_h,
  input  logic [DW-1:0] in_l,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_c,
  input  logic [DW-1:0] in_op0,
  input  logic [DW-1:0] in_op1,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr
);
  logic [AW-1:0] base;
  logic [DW-1:0] offs;
  logic [AW-1:0] sum;

  eagen_operand_sel #(.AW(AW), .DW(DW)) u_sel (
    .mode (ea_mode_e'(in_mode)),
    .h    (in_h),
    .l    (in_l),
    .b    (in_b),
    .c    (in_c),
    .op0  (in_op0),
    .op1  (in_op1),
    .base (base),
    .offs (offs)
  );

  eagen_adder #(.AW(AW), .DW(DW)) u_add (
    .base (base),
    .offs (offs),
    .sum  (sum)
  );

  eagen_out_stage #(.AW(AW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .next_addr (sum),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr)
  );
endmodule

// File: rtl/eagen_checker.sv
module eagen_checker #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_mode,
  input logic [DW-1:0] in_op0,
  input logic [DW-1:0] in_op1,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr
);
  localparam int HW = AW - DW;

  p_ready_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);

  p_page_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 3'd3) |=> (out_addr[AW-1:DW] == '0));

  p_absolute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mode == 3'd6)
      |=> (out_addr == {$past(in_op0[HW-1:0]), $past(in_op1)}));
endmodule

bind eagen_top eagen_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_mode   (in_mode),
  .in_op0    (in_op0),
  .in_op1    (in_op1),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr)
);

// File: tb/sim_eagen_top.sv
module sim_eagen_top;
  localparam int CLK_P = 10;
  localparam int NV    = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_mode = '0;
  logic [7:0] in_h = '0, in_l = '0, in_b = '0, in_c = '0, in_op0 = '0, in_op1 = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [11:0] out_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  eagen_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_h(in_h), .in_l(in_l), .in_b(in_b), .in_c(in_c),
    .in_op0(in_op0), .in_op1(in_op1), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr)
  );

  // {req_tag[3:0], mode[2:0], h, l, b, c, op0, op1, expected[11:0]}
  localparam logic [66:0] VEC [NV] = '{
    {4'd2,  3'd0, 8'h0A, 8'h34, 8'h00, 8'h00, 8'h00, 8'h00, 12'hA34}, // R2
    {4'd2,  3'd0, 8'hF5, 8'h01, 8'h11, 8'h22, 8'h33, 8'h44, 12'h501}, // R2 upper H ignored
    {4'd3,  3'd1, 8'h03, 8'hF0, 8'h20, 8'h77, 8'h00, 8'h00, 12'h410}, // R3 HL+B
    {4'd3,  3'd2, 8'h0F, 8'hFF, 8'h55, 8'h02, 8'h00, 8'h00, 12'h001}, // R3 HL+C wraps
    {4'd3,  3'd1, 8'h00, 8'h01, 8'hFF, 8'h00, 8'h00, 8'h00, 12'h100}, // R3 carry into page
    {4'd4,  3'd3, 8'h0B, 8'hCD, 8'h00, 8'h00, 8'h7C, 8'h00, 12'h07C}, // R4
    {4'd5,  3'd4, 8'h0E, 8'h99, 8'h00, 8'h00, 8'h55, 8'h00, 12'hE55}, // R5
    {4'd5,  3'd4, 8'hA2, 8'h99, 8'h00, 8'h00, 8'h00, 8'h00, 12'h200}, // R5
    {4'd6,  3'd5, 8'h01, 8'h80, 8'h00, 8'h00, 8'h90, 8'h00, 12'h210}, // R6
    {4'd6,  3'd5, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h20, 8'h00, 12'h010}, // R6 wraps
    {4'd7,  3'd6, 8'h05, 8'h66, 8'h00, 8'h00, 8'h0F, 8'h12, 12'hF12}, // R7
    {4'd7,  3'd6, 8'h05, 8'h66, 8'h00, 8'h00, 8'hC3, 8'hAB, 12'h3AB}, // R7 upper nibble ignored
    {4'd11, 3'd7, 8'h02, 8'h44, 8'h09, 8'h09, 8'h09, 8'h09, 12'h244}  // R11
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [7:0] h, input logic [7:0] l,
                       input logic [7:0] op0, input logic [7:0] op1);
    in_valid = 1'b1; in_mode = m; in_h = h; in_l = l;
    in_b = 8'h00; in_c = 8'h00; in_op0 = op0; in_op1 = op1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table, streamed back-to-back with consumer always ready
    for (int i = 0; i < NV; i++) begin
      logic [3:0] tg;
      tg = VEC[i][66:63];
      in_valid = 1'b1;
      in_mode  = VEC[i][62:60];
      in_h     = VEC[i][59:52];
      in_l     = VEC[i][51:44];
      in_b     = VEC[i][43:36];
      in_c     = VEC[i][35:28];
      in_op0   = VEC[i][27:20];
      in_op1   = VEC[i][19:12];
      @(negedge clk);
      check($sformatf("R%0d vec%0d valid", tg, i), {31'd0, out_valid}, 32'd1);
      check($sformatf("R%0d vec%0d addr", tg, i), {20'd0, out_addr}, {20'd0, VEC[i][11:0]});
    end

    // R10 drain with no new request
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 drain", {31'd0, out_valid}, 32'd0);

    // R8 timing: nothing before the edge, result right after
    drive(3'd3, 8'h00, 8'h00, 8'h5A, 8'h00);
    #1;
    check("R8 before edge", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R8 after edge", {31'd0, out_valid}, 32'd1);
    check("R8 addr", {20'd0, out_addr}, 32'h05A);

    // R9 stall: hold address, refuse new request
    out_ready = 1'b0;
    drive(3'd4, 8'h07, 8'h00, 8'h31, 8'h00);  // would be 731
    @(negedge clk);
    check("R9 stall in_ready", {31'd0, in_ready}, 32'd0);
    check("R9 stall valid", {31'd0, out_valid}, 32'd1);
    check("R9 stall addr held", {20'd0, out_addr}, 32'h05A);
    @(negedge clk);
    check("R9 stall addr still held", {20'd0, out_addr}, 32'h05A);
    // release: consume and accept on same edge
    out_ready = 1'b1;
    #1;
    check("R9 release in_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    check("R9 handover valid", {31'd0, out_valid}, 32'd1);
    check("R9 handover addr", {20'd0, out_addr}, 32'h731);

    // R4 H/L have no effect; R5 L has no effect (same request, different pointer)
    drive(3'd3, 8'h0F, 8'hEE, 8'hC8, 8'h00);
    @(negedge clk);
    check("R4 zero page ignores pointer", {20'd0, out_addr}, 32'h0C8);
    drive(3'd4, 8'h09, 8'h12, 8'hC8, 8'h00);
    @(negedge clk);
    check("R5 page ignores L", {20'd0, out_addr}, 32'h9C8);
    in_valid = 1'b0;
    @(negedge clk);
    check("R10 final drain", {31'd0, out_valid}, 32'd0);

    // R1 reset mid-operation
    drive(3'd0, 8'h01, 8'h01, 8'h00, 8'h00);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 reset clears valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset ready", {31'd0, in_ready}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule